// File: doc/BRIEF.md
# Two-Bus Signal Lookup and Output Slot Unit

This unit sits between an execution core and two external signal buses, called red and green. On every tick each bus presents a table of (id, count) entries, and each entry carries its own valid bit. The unit looks up one requested id in parallel across all entries. It answers with the red total, the green total, or the sum of both. An id that no valid entry carries reads as zero. For each bus it also reports how many distinct ids are currently present.

On the output side the unit holds four slots, and each slot stores an id and a count. A write names the slot and supplies the pair; the core decides whether the count came from a register or an immediate. All slots are driven onto the output bus continuously. A slot keeps its value until it is written again. Reads are combinational, and slot writes land on the next clock edge.

Top module: `dual_bus_sigio`

## Requirements
- R1: With `rd_src` = 0, `rd_value` equals the sum of the counts of all valid red entries whose id equals `rd_id`.
- R2: With `rd_src` = 1, `rd_value` equals the sum of the counts of all valid green entries whose id equals `rd_id`.
- R3: With `rd_src` = 2, `rd_value` equals the red result plus the green result, modulo 2^32. With `rd_src` = 3, `rd_value` is 0.
- R4: When no valid entry on the selected bus carries `rd_id`, that bus contributes 0.
- R5: When several valid entries of one bus share an id, a read of that id returns the sum of their counts, wrapping modulo 2^32.
- R6: `red_distinct` and `green_distinct` equal the number of different ids among the valid entries of that bus.
- R7: When `wr_en` is high at a rising edge, slot `wr_slot` shows `wr_id` and `wr_cnt` after that edge. Slot k occupies bits [k*ID_W +: ID_W] of `out_id` and bits [k*CNT_W +: CNT_W] of `out_cnt`.
- R8: A slot that is not written at an edge keeps its id and count. This holds for all slots while `wr_en` is low, whatever `wr_slot` and the write data are.
- R9: While `rst_n` is low, every slot is cleared to id 0 and count 0.
- R10: Entries whose valid bit is 0 add nothing to any read or distinct count, whatever id and count they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the output slots |
| red_valid | input | ENTRIES | Per-entry valid bits, red bus |
| red_id | input | ENTRIES*ID_W | Packed entry ids, red bus (entry e at e*ID_W) |
| red_cnt | input | ENTRIES*CNT_W | Packed entry counts, red bus |
| green_valid | input | ENTRIES | Per-entry valid bits, green bus |
| green_id | input | ENTRIES*ID_W | Packed entry ids, green bus |
| green_cnt | input | ENTRIES*CNT_W | Packed entry counts, green bus |
| rd_id | input | ID_W | Id to look up |
| rd_src | input | 2 | 0 red, 1 green, 2 both summed, 3 zero |
| rd_value | output | CNT_W | Lookup result |
| red_distinct | output | $clog2(ENTRIES+1) | Number of distinct valid ids on red |
| green_distinct | output | $clog2(ENTRIES+1) | Number of distinct valid ids on green |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | 2 | Slot number 0..3 |
| wr_id | input | ID_W | Id to store |
| wr_cnt | input | CNT_W | Count to store |
| out_id | output | SLOTS*ID_W | All slot ids, packed |
| out_cnt | output | SLOTS*CNT_W | All slot counts, packed |

## Verification
The hardest cases to reach are those where duplicate ids and invalid entries occur on the same bus. In these cases the read sum, the distinct count and the wrap of the combined total all depend on which entries match. The stimulus therefore builds whole bus tables from formulas: ids repeat modulo a small number, counts sit near 2^31 so that sums overflow, and valid bits alternate. Invalid entries carry the queried id and a large count, so that a leak would show. Every id from 0 past the largest one present is then swept under all four source codes.

// File: rtl/sigio_pkg.sv
package sigio_pkg;
   typedef enum logic [1:0] {
      SRC_RED   = 2'd0,
      SRC_GREEN = 2'd1,
      SRC_BOTH  = 2'd2,
      SRC_NONE  = 2'd3
   } rd_src_e;
endpackage

// File: rtl/sigio_bus_lookup.sv
module sigio_bus_lookup #(
   parameter int ENTRIES = 16,
   parameter int ID_W    = 16,
   parameter int CNT_W   = 32,
   localparam int DW     = $clog2(ENTRIES + 1)
) (
   input  logic [ENTRIES-1:0]       ent_valid,
   input  logic [ENTRIES*ID_W-1:0]  ent_id,
   input  logic [ENTRIES*CNT_W-1:0] ent_cnt,
   input  logic [ID_W-1:0]          q_id,
   output logic [CNT_W-1:0]         q_sum,
   output logic [DW-1:0]            n_distinct
);
   logic [ID_W-1:0]  ids  [ENTRIES];
   logic [CNT_W-1:0] cnts [ENTRIES];
   logic [ENTRIES-1:0] hit;
   logic [ENTRIES-1:0] first_seen;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign ids[e]  = ent_id[e*ID_W +: ID_W];
      assign cnts[e] = ent_cnt[e*CNT_W +: CNT_W];
      assign hit[e]  = ent_valid[e] && (ids[e] == q_id);
      if (e == 0) begin : g_head
         assign first_seen[e] = ent_valid[e];
      end else begin : g_tail
         logic [e-1:0] dup;
         for (genvar j = 0; j < e; j++) begin : g_cmp
            assign dup[j] = ent_valid[j] && (ids[j] == ids[e]);
         end
         assign first_seen[e] = ent_valid[e] && (dup == '0);
      end
   end

   always_comb begin
      q_sum = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (hit[e]) q_sum = q_sum + cnts[e];
      end
   end

   always_comb begin
      n_distinct = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         n_distinct = n_distinct + DW'(first_seen[e]);
      end
   end
endmodule

// File: rtl/sigio_out_slots.sv
module sigio_out_slots #(
   parameter int SLOTS = 4,
   parameter int ID_W  = 16,
   parameter int CNT_W = 32,
   localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SW-1:0]          wr_slot,
   input  logic [ID_W-1:0]        wr_id,
   input  logic [CNT_W-1:0]       wr_cnt,
   output logic [SLOTS*ID_W-1:0]  out_id,
   output logic [SLOTS*CNT_W-1:0] out_cnt
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [ID_W-1:0]  id_q;
      logic [CNT_W-1:0] cnt_q;
      logic sel;
      assign sel = wr_en && (wr_slot == SW'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_q  <= '0;
            cnt_q <= '0;
         end else if (sel) begin
            id_q  <= wr_id;
            cnt_q <= wr_cnt;
         end
      end
      assign out_id[s*ID_W +: ID_W]    = id_q;
      assign out_cnt[s*CNT_W +: CNT_W] = cnt_q;
   end
endmodule

// File: rtl/dual_bus_sigio.sv
module dual_bus_sigio
   import sigio_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int ID_W    = 16,
   parameter int CNT_W   = 32,
   parameter int SLOTS   = 4,
   localparam int DW     = $clog2(ENTRIES + 1),
   localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ENTRIES-1:0]       red_valid,
   input  logic [ENTRIES*ID_W-1:0]  red_id,
   input  logic [ENTRIES*CNT_W-1:0] red_cnt,
   input  logic [ENTRIES-1:0]       green_valid,
   input  logic [ENTRIES*ID_W-1:0]  green_id,
   input  logic [ENTRIES*CNT_W-1:0] green_cnt,
   input  logic [ID_W-1:0]          rd_id,
   input  logic [1:0]               rd_src,
   output logic [CNT_W-1:0]         rd_value,
   output logic [DW-1:0]            red_distinct,
   output logic [DW-1:0]            green_distinct,
   input  logic                     wr_en,
   input  logic [SW-1:0]            wr_slot,
   input  logic [ID_W-1:0]          wr_id,
   input  logic [CNT_W-1:0]         wr_cnt,
   output logic [SLOTS*ID_W-1:0]    out_id,
   output logic [SLOTS*CNT_W-1:0]   out_cnt
);
   if (ENTRIES < 1 || ID_W < 1 || CNT_W < 1 || SLOTS < 1) begin : g_bad_cfg
      $error("dual_bus_sigio: ENTRIES, ID_W, CNT_W and SLOTS must be positive");
   end

   logic [CNT_W-1:0] red_sum, green_sum;

   sigio_bus_lookup #(.ENTRIES(ENTRIES), .ID_W(ID_W), .CNT_W(CNT_W)) red_lu_i (
      .ent_valid(red_valid), .ent_id(red_id), .ent_cnt(red_cnt),
      .q_id(rd_id), .q_sum(red_sum), .n_distinct(red_distinct));

   sigio_bus_lookup #(.ENTRIES(ENTRIES), .ID_W(ID_W), .CNT_W(CNT_W)) green_lu_i (
      .ent_valid(green_valid), .ent_id(green_id), .ent_cnt(green_cnt),
      .q_id(rd_id), .q_sum(green_sum), .n_distinct(green_distinct));

   always_comb begin
      unique case (rd_src_e'(rd_src))
         SRC_RED:   rd_value = red_sum;
         SRC_GREEN: rd_value = green_sum;
         SRC_BOTH:  rd_value = red_sum + green_sum;
         default:   rd_value = '0;
      endcase
   end

   sigio_out_slots #(.SLOTS(SLOTS), .ID_W(ID_W), .CNT_W(CNT_W)) slots_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_id(wr_id), .wr_cnt(wr_cnt), .out_id(out_id), .out_cnt(out_cnt));
endmodule

// File: rtl/dual_bus_sigio_chk.sv
module dual_bus_sigio_chk #(
   parameter int ENTRIES = 16,
   parameter int ID_W    = 16,
   parameter int CNT_W   = 32,
   parameter int SLOTS   = 4,
   localparam int DW     = $clog2(ENTRIES + 1),
   localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ENTRIES-1:0]     red_valid,
   input logic [ENTRIES-1:0]     green_valid,
   input logic [1:0]             rd_src,
   input logic [CNT_W-1:0]       rd_value,
   input logic [DW-1:0]          red_distinct,
   input logic [DW-1:0]          green_distinct,
   input logic                   wr_en,
   input logic [SW-1:0]          wr_slot,
   input logic [ID_W-1:0]        wr_id,
   input logic [CNT_W-1:0]       wr_cnt,
   input logic [SLOTS*ID_W-1:0]  out_id,
   input logic [SLOTS*CNT_W-1:0] out_cnt
);
   a_r9_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (out_id == '0 && out_cnt == '0));

   a_r10_red_distinct_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(red_distinct) <= $countones(red_valid));

   a_r10_green_distinct_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(green_distinct) <= $countones(green_valid));

   a_r4_empty_red_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (red_valid == '0 && rd_src == 2'd0) |-> rd_value == '0);

   a_r3_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src == 2'd3) |-> rd_value == '0);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
      a_r7_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_slot == SW'(s)) |=>
            (out_id[s*ID_W +: ID_W] == $past(wr_id) &&
             out_cnt[s*CNT_W +: CNT_W] == $past(wr_cnt)));

      a_r8_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_slot == SW'(s)) |=>
            ($stable(out_id[s*ID_W +: ID_W]) && $stable(out_cnt[s*CNT_W +: CNT_W])));
   end
endmodule

bind dual_bus_sigio dual_bus_sigio_chk #(
   .ENTRIES(ENTRIES), .ID_W(ID_W), .CNT_W(CNT_W), .SLOTS(SLOTS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .red_valid(red_valid), .green_valid(green_valid),
   .rd_src(rd_src), .rd_value(rd_value), .red_distinct(red_distinct),
   .green_distinct(green_distinct), .wr_en(wr_en), .wr_slot(wr_slot),
   .wr_id(wr_id), .wr_cnt(wr_cnt), .out_id(out_id), .out_cnt(out_cnt)
);

// File: tb/dual_bus_sigio_tb_top.sv
module dual_bus_sigio_tb_top;
   localparam int N  = 16;
   localparam int IW = 16;
   localparam int CW = 32;
   localparam int S  = 4;
   localparam int DW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] red_valid = '0, green_valid = '0;
   logic [N*IW-1:0] red_id = '0, green_id = '0;
   logic [N*CW-1:0] red_cnt = '0, green_cnt = '0;
   logic [IW-1:0] rd_id = '0;
   logic [1:0] rd_src = '0;
   logic [CW-1:0] rd_value;
   logic [DW-1:0] red_distinct, green_distinct;
   logic wr_en = 1'b0;
   logic [1:0] wr_slot = '0;
   logic [IW-1:0] wr_id = '0;
   logic [CW-1:0] wr_cnt = '0;
   logic [S*IW-1:0] out_id;
   logic [S*CW-1:0] out_cnt;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench-side bus tables, index 0 = red, 1 = green
   bit          tv [2][N];
   logic [IW-1:0] tid [2][N];
   logic [CW-1:0] tcnt[2][N];
   logic [IW-1:0] slot_id_m [S];
   logic [CW-1:0] slot_cnt_m[S];

   always #4 clk = ~clk;

   dual_bus_sigio dut_i (
      .clk(clk), .rst_n(rst_n),
      .red_valid(red_valid), .red_id(red_id), .red_cnt(red_cnt),
      .green_valid(green_valid), .green_id(green_id), .green_cnt(green_cnt),
      .rd_id(rd_id), .rd_src(rd_src), .rd_value(rd_value),
      .red_distinct(red_distinct), .green_distinct(green_distinct),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_id(wr_id), .wr_cnt(wr_cnt),
      .out_id(out_id), .out_cnt(out_cnt));

   task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic apply_tables();
      for (int e = 0; e < N; e++) begin
         red_valid[e] = tv[0][e];
         red_id[e*IW +: IW] = tid[0][e];
         red_cnt[e*CW +: CW] = tcnt[0][e];
         green_valid[e] = tv[1][e];
         green_id[e*IW +: IW] = tid[1][e];
         green_cnt[e*CW +: CW] = tcnt[1][e];
      end
   endtask

   function automatic logic [CW-1:0] model_sum(input int b, input logic [IW-1:0] id);
      logic [CW-1:0] acc = '0;
      for (int e = 0; e < N; e++)
         if (tv[b][e] && tid[b][e] == id) acc = acc + tcnt[b][e];
      return acc;
   endfunction

   function automatic int model_distinct(input int b);
      int n = 0;
      for (int e = 0; e < N; e++) begin
         bit seen = 1'b0;
         for (int j = 0; j < e; j++)
            if (tv[b][j] && tid[b][j] == tid[b][e]) seen = 1'b1;
         if (tv[b][e] && !seen) n++;
      end
      return n;
   endfunction

   // sweep ids 0..max_id under all four source codes
   task automatic sweep(input string tag, input int max_id);
      for (int q = 0; q <= max_id; q++) begin
         for (int s = 0; s < 4; s++) begin
            logic [CW-1:0] exp;
            @(negedge clk);
            rd_id = IW'(q);
            rd_src = 2'(s);
            #1;
            case (s)
               0: exp = model_sum(0, IW'(q));
               1: exp = model_sum(1, IW'(q));
               2: exp = model_sum(0, IW'(q)) + model_sum(1, IW'(q));
               default: exp = '0;
            endcase
            check($sformatf("%s src%0d id%0d", tag, s, q), rd_value, exp);
         end
      end
      check({tag, " R6 red distinct"}, CW'(red_distinct), CW'(model_distinct(0)));
      check({tag, " R6 green distinct"}, CW'(green_distinct), CW'(model_distinct(1)));
   endtask

   task automatic check_slots(input string tag);
      for (int s = 0; s < S; s++) begin
         check($sformatf("%s slot%0d id", tag, s), CW'(out_id[s*IW +: IW]), CW'(slot_id_m[s]));
         check($sformatf("%s slot%0d cnt", tag, s), out_cnt[s*CW +: CW], slot_cnt_m[s]);
      end
   endtask

   task automatic write_slot(input int s, input logic [IW-1:0] id, input logic [CW-1:0] c, input bit en);
      @(negedge clk);
      wr_en = en; wr_slot = 2'(s); wr_id = id; wr_cnt = c;
      @(negedge clk);
      wr_en = 1'b0;
      if (en) begin slot_id_m[s] = id; slot_cnt_m[s] = c; end
   endtask

   task automatic clear_model();
      for (int s = 0; s < S; s++) begin slot_id_m[s] = '0; slot_cnt_m[s] = '0; end
   endtask

   initial begin
      clear_model();
      for (int b = 0; b < 2; b++)
         for (int e = 0; e < N; e++) begin tv[b][e] = 0; tid[b][e] = '0; tcnt[b][e] = '0; end
      apply_tables();
      repeat (3) @(negedge clk);
      check_slots("R9 reset");
      rst_n = 1'b1;
      // empty buses: everything absent (R4)
      sweep("R4 empty", 3);

      // red distinct ids, green empty (R1, R4)
      for (int e = 0; e < N; e++) begin
         tv[0][e] = 1; tid[0][e] = IW'(e + 1); tcnt[0][e] = CW'(e * 100 + 7);
      end
      apply_tables();
      sweep("R1 R4 red only", N + 3);

      // green distinct, red empty (R2)
      for (int e = 0; e < N; e++) begin
         tv[0][e] = 0;
         tv[1][e] = 1; tid[1][e] = IW'(3 * e); tcnt[1][e] = CW'(32'h0001_0000 + e);
      end
      apply_tables();
      sweep("R2 green only", 3 * N);

      // duplicates and wrap on both buses (R3, R5)
      for (int e = 0; e < N; e++) begin
         tv[0][e] = 1; tid[0][e] = IW'(e % 4 + 1); tcnt[0][e] = CW'(32'h8000_0000 + e);
         tv[1][e] = 1; tid[1][e] = IW'(e % 3 + 2); tcnt[1][e] = CW'(32'hC000_0000 + 5 * e);
      end
      apply_tables();
      sweep("R3 R5 dup wrap", 6);

      // invalid entries carry queried ids and large counts (R10)
      for (int e = 0; e < N; e++) begin
         tv[0][e] = e[0]; tid[0][e] = e[0] ? IW'(e % 5) : IW'(2);
         tcnt[0][e] = e[0] ? CW'(e) : 32'hDEAD_0000;
         tv[1][e] = (e % 3 == 0); tid[1][e] = (e % 3 == 0) ? IW'(7) : IW'(e);
         tcnt[1][e] = (e % 3 == 0) ? CW'(e + 1) : 32'h7777_7777;
      end
      apply_tables();
      sweep("R10 invalid", N);

      // output slots (R7, R8)
      for (int s = 0; s < S; s++) begin
         write_slot(s, IW'(16'h100 + s), CW'(32'hA500_0000 + s * 3), 1'b1);
         check_slots($sformatf("R7 write slot%0d", s));
      end
      write_slot(2, 16'hFFFF, 32'hFFFF_FFFF, 1'b1);
      check_slots("R7 rewrite slot2");
      for (int s = 0; s < S; s++) begin
         write_slot(s, 16'h5A5A, 32'h1234_5678, 1'b0);
         check_slots($sformatf("R8 no-write slot%0d", s));
      end
      repeat (5) @(negedge clk);
      check_slots("R8 idle hold");

      // reset mid-run clears (R9)
      rst_n = 1'b0;
      clear_model();
      @(negedge clk);
      check_slots("R9 mid reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_slots("R9 after release");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule